// File: doc/BRIEF.md
# Float to Fixed-Point Converter

This block turns an IEEE-754 operand, either single or double precision, into a fixed-point integer. The integer is 16 or 32 bits wide and may be signed or unsigned. The caller sets the binary point with a 5-bit immediate taken from an instruction encoding. The number of fraction bits is the chosen width less the immediate. The operand is scaled by that power of two and then truncated toward zero. A result that does not fit the chosen width and signedness is clamped to the nearest bound, and the invalid-operation flag is raised.

A double operand arrives as two 32-bit words. The 64-bit result leaves the same way. A signed result is sign-extended to 64 bits and an unsigned result is zero-extended. The conversion is combinational. It is captured in one output register when `in_valid` is high, so the result appears one cycle later.

Top module: `fp2fix_cvt`

## Requirements
- R1: The fraction-bit count is F = B - M. B is 16 when `is_word` is 0 and 32 when it is 1. M is the 5-bit value {`imm_hi`, `imm_lo`}, with `imm_lo` as its least significant bit. The operand is multiplied by 2^F before conversion, and F may be negative.
- R2: The scaled value is truncated toward zero for both signs. Any fractional part is dropped.
- R3: Signed mode with `is_word`=0: a scaled value below -32768 gives -32768, a value above 32767 gives 32767, and either case raises `invalid`. All signed 16-bit results are sign-extended to 64 bits.
- R4: Signed mode with `is_word`=1: a scaled value below -2^31 gives -2^31, a value above 2^31-1 gives 2^31-1, and either case raises `invalid`.
- R5: Unsigned mode: any negative nonzero operand gives 0 with `invalid` raised. This includes values between -1 and 0 and negative infinity. Negative zero gives 0 with no flag. A scaled value above 2^W-1 (W = 16 or 32) gives 2^W-1 with `invalid` raised.
- R6: The bounds are compared against the exact scaled value. A value that lies above the upper bound, or below the lower bound, by less than one unit still raises `invalid`, even though it truncates to the bound.
- R7: A NaN operand (exponent all ones, fraction nonzero) gives 0 with `invalid` raised.
- R8: An infinite operand gives the bound on its side for the selected mode, with `invalid` raised.
- R9: When `is_double`=1 the operand is {`op_hi`, `op_lo`}. When `is_double`=0 only `op_lo` is the operand and `op_hi` has no effect. The result is returned with bits 63:32 on `res_hi` and bits 31:0 on `res_lo`.
- R10: `out_valid` is high exactly in the cycle after a cycle with `in_valid` high. Results and flag hold while `in_valid` is low. Reset clears `out_valid`, the result and the flag to 0.
- R11: An in-range conversion leaves `invalid` low. Unsigned results are zero-extended to 64 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand and controls valid this cycle |
| is_double | input | 1 | 1: double-precision operand, 0: single |
| is_signed | input | 1 | 1: signed result, 0: unsigned |
| is_word | input | 1 | 1: 32-bit result, 0: 16-bit result |
| imm_lo | input | 1 | Least significant bit of the immediate |
| imm_hi | input | 4 | Upper four bits of the immediate |
| op_lo | input | 32 | Operand bits 31:0 (whole single operand) |
| op_hi | input | 32 | Operand bits 63:32 for a double |
| out_valid | output | 1 | Registered result valid |
| res_lo | output | 32 | Result bits 31:0 |
| res_hi | output | 32 | Result bits 63:32 (sign or zero extension) |
| invalid | output | 1 | Invalid-operation flag for the result |

## Verification
The hardest case to reach is a scaled value that sits just past a bound by a fraction. It truncates to the bound, yet the flag must still rise. From the ports this needs both the right mantissa and the one immediate that places the binary point exactly there. The stimulus therefore sweeps every immediate for every precision, width and signedness. It uses a fixed set of mantissas built just around 2^15, 2^16, 2^31 and 2^32, together with pseudo-random operands. Each of these values then lands below, on and just past every bound under some scale. The expected value comes from real arithmetic on the decoded operand.

// File: rtl/fp2fix_pkg.sv
package fp2fix_pkg;

   // widest significand handled (double, hidden bit included)
   localparam int SIG_W   = 53;
   // signed unbiased exponent plus scale, wide enough for double range + shift
   localparam int EXP_S_W = 14;

   typedef enum logic [1:0] {
      CLS_ZERO = 2'd0,
      CLS_FIN  = 2'd1,
      CLS_INF  = 2'd2,
      CLS_NAN  = 2'd3
   } fp_cls_e;

   // common form of either precision: significand left-aligned so the
   // hidden-bit position is always SIG_W-1
   typedef struct packed {
      fp_cls_e                    cls;
      logic                       sign;
      logic signed [EXP_S_W-1:0]  uexp;
      logic [SIG_W-1:0]           sig;
   } fp_parts_t;

endpackage

// File: rtl/fp_unpack.sv
module fp_unpack
   import fp2fix_pkg::*;
#(
   parameter int EXP_W = 8,
   parameter int MAN_W = 23
) (
   input  logic [EXP_W+MAN_W:0] raw,
   output fp_parts_t            parts
);

   localparam int BIAS = (1 << (EXP_W - 1)) - 1;
   localparam int PAD  = SIG_W - 1 - MAN_W;

   if (PAD < 0) begin : g_chk_pad
      $error("fp_unpack: mantissa wider than package significand");
   end
   if (EXP_W + 2 > EXP_S_W) begin : g_chk_exp
      $error("fp_unpack: exponent does not fit signed exponent field");
   end

   logic [EXP_W-1:0] exp_f;
   logic [MAN_W-1:0] man_f;
   logic             exp_ones;
   logic             exp_zero;
   logic [EXP_W-1:0] exp_eff;
   logic             hidden;

   assign exp_f    = raw[EXP_W+MAN_W-1:MAN_W];
   assign man_f    = raw[MAN_W-1:0];
   assign exp_ones = &exp_f;
   assign exp_zero = (exp_f == '0);
   assign hidden   = !exp_zero;
   // subnormals use the minimum exponent with no hidden bit
   assign exp_eff  = exp_zero ? EXP_W'(1) : exp_f;

   always_comb begin
      if (exp_ones)
         parts.cls = (man_f != '0) ? CLS_NAN : CLS_INF;
      else if (exp_zero && man_f == '0)
         parts.cls = CLS_ZERO;
      else
         parts.cls = CLS_FIN;
   end

   assign parts.sign = raw[EXP_W+MAN_W];
   assign parts.uexp = $signed(EXP_S_W'(exp_eff)) - $signed(EXP_S_W'(BIAS));

   if (PAD > 0) begin : g_pad
      assign parts.sig = {hidden, man_f, {PAD{1'b0}}};
   end else begin : g_nopad
      assign parts.sig = {hidden, man_f};
   end

endmodule

// File: rtl/fx_scale.sv
module fx_scale
   import fp2fix_pkg::*;
#(
   parameter int INT_W = 34,
   parameter int FB_W  = 7
) (
   input  fp_parts_t              parts,
   input  logic signed [FB_W-1:0] fbits,
   output logic [INT_W-1:0]       int_part,
   output logic                   frac_nz,
   output logic                   huge
);

   localparam int SH_W = $clog2(SIG_W) + 1;
   localparam logic signed [EXP_S_W-1:0] INT_LIM = EXP_S_W'(INT_W);
   localparam logic signed [EXP_S_W-1:0] SIG_TOP = EXP_S_W'(SIG_W - 1);
   localparam logic signed [EXP_S_W-1:0] SIG_LEN = EXP_S_W'(SIG_W);

   if (INT_W >= SIG_W) begin : g_chk_int
      $error("fx_scale: integer field must be narrower than significand");
   end
   if (FB_W >= EXP_S_W) begin : g_chk_fb
      $error("fx_scale: scale field too wide");
   end

   logic signed [EXP_S_W-1:0] msb;
   logic signed [EXP_S_W-1:0] rs;
   logic [SH_W-1:0]           rs_c;
   logic [SIG_W-1:0]          keep_mask;

   // weight of the hidden-bit position after scaling by 2^fbits
   assign msb  = parts.uexp + {{(EXP_S_W-FB_W){fbits[FB_W-1]}}, fbits};
   assign huge = (parts.sig != '0) && (msb >= INT_LIM);
   assign rs   = SIG_TOP - msb;

   always_comb begin
      if (rs < 0)
         rs_c = '0;
      else if (rs >= SIG_LEN)
         rs_c = SH_W'(SIG_W);
      else
         rs_c = rs[SH_W-1:0];
   end

   assign int_part  = INT_W'(parts.sig >> rs_c);
   assign keep_mask = ~({SIG_W{1'b1}} << rs_c);
   assign frac_nz   = |(parts.sig & keep_mask);

endmodule

// File: rtl/fx_saturate.sv
module fx_saturate
   import fp2fix_pkg::*;
#(
   parameter int INT_W  = 34,
   parameter int HALF_W = 16,
   parameter int WORD_W = 32,
   parameter int OUT_W  = 64
) (
   input  fp_cls_e            cls,
   input  logic               sign,
   input  logic [INT_W-1:0]   int_part,
   input  logic               frac_nz,
   input  logic               huge,
   input  logic               is_signed,
   input  logic               is_word,
   output logic [OUT_W-1:0]   result,
   output logic               invalid
);

   localparam int W_SH = $clog2(OUT_W) + 1;
   localparam logic [OUT_W-1:0] ONE = OUT_W'(1);

   if (WORD_W >= OUT_W || HALF_W >= WORD_W) begin : g_chk_w
      $error("fx_saturate: widths must satisfy HALF_W < WORD_W < OUT_W");
   end
   if (INT_W > OUT_W) begin : g_chk_int
      $error("fx_saturate: integer field wider than output");
   end

   logic [W_SH-1:0]  w;
   logic [OUT_W-1:0] mag;
   logic [OUT_W-1:0] s_neg_mag;
   logic [OUT_W-1:0] s_max;
   logic [OUT_W-1:0] u_max;
   logic             is_inf;
   logic             pos_over_s;
   logic             neg_over_s;
   logic             pos_over_u;

   assign w         = is_word ? W_SH'(WORD_W) : W_SH'(HALF_W);
   assign mag       = OUT_W'(int_part);
   assign s_neg_mag = ONE << (w - W_SH'(1));
   assign s_max     = s_neg_mag - ONE;
   assign u_max     = (ONE << w) - ONE;
   assign is_inf    = (cls == CLS_INF);

   // exact comparison: a discarded fraction on top of the bound still exceeds it
   assign pos_over_s = is_inf || huge || (mag > s_max) ||
                       ((mag == s_max) && frac_nz);
   assign neg_over_s = is_inf || huge || (mag > s_neg_mag) ||
                       ((mag == s_neg_mag) && frac_nz);
   assign pos_over_u = is_inf || huge || (mag > u_max) ||
                       ((mag == u_max) && frac_nz);

   always_comb begin
      result  = mag;
      invalid = 1'b0;
      if (cls == CLS_NAN) begin
         result  = '0;
         invalid = 1'b1;
      end else if (is_signed) begin
         if (!sign) begin
            if (pos_over_s) begin
               result  = s_max;
               invalid = 1'b1;
            end
         end else begin
            if (neg_over_s) begin
               result  = ~s_max;
               invalid = 1'b1;
            end else begin
               result  = ~mag + ONE;
            end
         end
      end else begin
         if (sign && cls != CLS_ZERO) begin
            result  = '0;
            invalid = 1'b1;
         end else if (pos_over_u) begin
            result  = u_max;
            invalid = 1'b1;
         end
      end
   end

endmodule

// File: rtl/fp2fix_cvt.sv
module fp2fix_cvt
   import fp2fix_pkg::*;
#(
   parameter int SGL_EXP_W = 8,
   parameter int SGL_MAN_W = 23,
   parameter int DBL_EXP_W = 11,
   parameter int DBL_MAN_W = 52,
   parameter int HALF_W    = 16,
   parameter int WORD_W    = 32,
   parameter int IMM_W     = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic              is_double,
   input  logic              is_signed,
   input  logic              is_word,
   input  logic              imm_lo,
   input  logic [IMM_W-2:0]  imm_hi,
   input  logic [WORD_W-1:0] op_lo,
   input  logic [WORD_W-1:0] op_hi,
   output logic              out_valid,
   output logic [WORD_W-1:0] res_lo,
   output logic [WORD_W-1:0] res_hi,
   output logic              invalid
);

   localparam int OUT_W = 2 * WORD_W;
   localparam int INT_W = WORD_W + 2;
   localparam int FB_W  = $clog2(WORD_W) + 2;

   if (SGL_EXP_W + SGL_MAN_W + 1 != WORD_W) begin : g_chk_sgl
      $error("fp2fix_cvt: single format must fill one word");
   end
   if (DBL_EXP_W + DBL_MAN_W + 1 != OUT_W) begin : g_chk_dbl
      $error("fp2fix_cvt: double format must fill two words");
   end
   if (DBL_MAN_W + 1 != SIG_W) begin : g_chk_sig
      $error("fp2fix_cvt: package significand width mismatch");
   end
   if ((1 << IMM_W) > (1 << (FB_W - 1)) + WORD_W) begin : g_chk_imm
      $error("fp2fix_cvt: immediate range exceeds scale field");
   end

   // ---------------- operand unpack ----------------
   fp_parts_t sgl_parts;
   fp_parts_t dbl_parts;
   fp_parts_t sel_parts;

   fp_unpack #(.EXP_W(SGL_EXP_W), .MAN_W(SGL_MAN_W)) u_unpack_sgl (
      .raw   (op_lo),
      .parts (sgl_parts)
   );

   fp_unpack #(.EXP_W(DBL_EXP_W), .MAN_W(DBL_MAN_W)) u_unpack_dbl (
      .raw   ({op_hi, op_lo}),
      .parts (dbl_parts)
   );

   assign sel_parts = is_double ? dbl_parts : sgl_parts;

   // ---------------- scale decode ----------------
   logic [IMM_W-1:0]        imm;
   logic signed [FB_W-1:0]  fbits;

   assign imm   = {imm_hi, imm_lo};
   assign fbits = (is_word ? FB_W'(WORD_W) : FB_W'(HALF_W)) - FB_W'(imm);

   // ---------------- scale and clamp ----------------
   logic [INT_W-1:0] int_part;
   logic             frac_nz;
   logic             huge;
   logic [OUT_W-1:0] conv_res;
   logic             conv_inv;

   fx_scale #(.INT_W(INT_W), .FB_W(FB_W)) u_scale (
      .parts    (sel_parts),
      .fbits    (fbits),
      .int_part (int_part),
      .frac_nz  (frac_nz),
      .huge     (huge)
   );

   fx_saturate #(
      .INT_W  (INT_W),
      .HALF_W (HALF_W),
      .WORD_W (WORD_W),
      .OUT_W  (OUT_W)
   ) u_sat (
      .cls       (sel_parts.cls),
      .sign      (sel_parts.sign),
      .int_part  (int_part),
      .frac_nz   (frac_nz),
      .huge      (huge),
      .is_signed (is_signed),
      .is_word   (is_word),
      .result    (conv_res),
      .invalid   (conv_inv)
   );

   // ---------------- output register ----------------
   logic [OUT_W-1:0] res_q;
   logic             inv_q;
   logic             vld_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         res_q <= '0;
         inv_q <= 1'b0;
         vld_q <= 1'b0;
      end else begin
         vld_q <= in_valid;
         if (in_valid) begin
            res_q <= conv_res;
            inv_q <= conv_inv;
         end
      end
   end

   assign out_valid = vld_q;
   assign res_lo    = res_q[WORD_W-1:0];
   assign res_hi    = res_q[OUT_W-1:WORD_W];
   assign invalid   = inv_q;

   // ---------------- assertions ----------------
   p_valid_lat_r10: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);

   p_valid_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);

   p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> ($stable(res_q) && $stable(inv_q)));

   p_zext_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !is_signed) |=> (res_hi == '0));

   p_sext_half_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && is_signed && !is_word) |=>
         ($countones(res_q[OUT_W-1:HALF_W-1]) == 0 ||
          $countones(res_q[OUT_W-1:HALF_W-1]) == OUT_W - HALF_W + 1));

   p_nan_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && sel_parts.cls == CLS_NAN) |=> (inv_q && res_q == '0));

   p_inf_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && sel_parts.cls == CLS_INF) |=> inv_q);

endmodule

// File: tb/tb_fp2fix_cvt.sv
`timescale 1ns/1ps
module tb_fp2fix_cvt;

   localparam int E_ZERO = -1000;
   localparam int E_SPEC = 1000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic        is_double = 1'b0;
   logic        is_signed = 1'b0;
   logic        is_word = 1'b0;
   logic        imm_lo = 1'b0;
   logic [3:0]  imm_hi = '0;
   logic [31:0] op_lo = '0;
   logic [31:0] op_hi = '0;
   logic        out_valid;
   logic [31:0] res_lo;
   logic [31:0] res_hi;
   logic        invalid;

   int          n_chk = 0;
   int          n_fail = 0;
   logic [31:0] lcg = 32'h1234_5678;

   always #2 clk = ~clk;

   fp2fix_cvt dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .is_double (is_double),
      .is_signed (is_signed),
      .is_word   (is_word),
      .imm_lo    (imm_lo),
      .imm_hi    (imm_hi),
      .op_lo     (op_lo),
      .op_hi     (op_hi),
      .out_valid (out_valid),
      .res_lo    (res_lo),
      .res_hi    (res_hi),
      .invalid   (invalid)
   );

   function automatic logic [31:0] rnd();
      lcg = lcg * 32'd1664525 + 32'd1013904223;
      return lcg;
   endfunction

   function automatic real sgl_val(input logic [31:0] b);
      real mag;
      int  e;
      e = int'(b[30:23]);
      if (e == 0) mag = real'(b[22:0]) * (2.0 ** (-149.0));
      else        mag = (1.0 + real'(b[22:0]) / 8388608.0) * (2.0 ** (real'(e) - 127.0));
      return b[31] ? -mag : mag;
   endfunction

   function automatic longint trunc_r(input real x);
      longint li;
      li = longint'(x);
      if (x >= 0.0 && real'(li) > x) li = li - 1;
      if (x < 0.0 && real'(li) < x) li = li + 1;
      return li;
   endfunction

   function automatic logic [63:0] mk(input bit dbl, input bit s, input int e,
                                      input logic [22:0] f, input logic [28:0] low);
      logic [7:0]  e8;
      logic [10:0] e11;
      logic [28:0] lw;
      e8  = (e == E_ZERO) ? 8'h00  : (e == E_SPEC) ? 8'hFF  : 8'(e + 127);
      e11 = (e == E_ZERO) ? 11'h0  : (e == E_SPEC) ? 11'h7FF : 11'(e + 1023);
      lw  = (e == E_ZERO || e == E_SPEC) ? 29'h0 : low;
      if (dbl) return {s, e11, f, lw};
      return {32'h0, s, e8, f};
   endfunction

   task automatic entry(input int i, output bit s, output int e, output logic [22:0] f);
      s = 1'b0; e = 0; f = '0;
      case (i)
         0:  begin s = 0; e = E_ZERO; f = 23'h0;      end
         1:  begin s = 1; e = E_ZERO; f = 23'h0;      end
         2:  begin s = 0; e = 0;      f = 23'h400000; end
         3:  begin s = 1; e = 0;      f = 23'h400000; end
         4:  begin s = 0; e = -1;     f = 23'h400000; end
         5:  begin s = 1; e = -1;     f = 23'h0;      end
         6:  begin s = 0; e = 14;     f = 23'h7FFF00; end
         7:  begin s = 1; e = 15;     f = 23'h0;      end
         8:  begin s = 1; e = 15;     f = 23'h000080; end
         9:  begin s = 0; e = 15;     f = 23'h7FFF00; end
         10: begin s = 0; e = 31;     f = 23'h0;      end
         11: begin s = 1; e = 31;     f = 23'h0;      end
         12: begin s = 1; e = 31;     f = 23'h000001; end
         13: begin s = 0; e = 31;     f = 23'h7FFFFF; end
         14: begin s = 0; e = 40;     f = 23'h123456; end
         15: begin s = 1; e = 40;     f = 23'h0;      end
         16: begin s = 0; e = E_SPEC; f = 23'h0;      end
         17: begin s = 1; e = E_SPEC; f = 23'h0;      end
         18: begin s = 0; e = E_SPEC; f = 23'h400000; end
         19: begin s = 1; e = E_SPEC; f = 23'h000001; end
         20: begin s = 0; e = E_ZERO; f = 23'h000123; end
         21: begin s = 1; e = E_ZERO; f = 23'h000123; end
         default: begin s = 0; e = -20; f = 23'h2AAAAA; end
      endcase
   endtask

   // called at a falling edge; drives one operation and checks it one cycle later
   task automatic run_op(input bit dbl, input bit sgn, input bit wd,
                         input logic [4:0] im, input logic [63:0] bits);
      real         v, sc, hi_r, lo_r, um_r;
      bit          nan, inf, neg, over_frac, sticky;
      int          w, fb;
      logic [63:0] eres, got;
      bit          einv;
      string       tag;
      longint      t;
      if (dbl) begin
         nan = (&bits[62:52]) && (|bits[51:0]);
         inf = (&bits[62:52]) && !(|bits[51:0]);
         neg = bits[63];
         v   = (nan || inf) ? 0.0 : $bitstoreal(bits);
      end else begin
         nan = (&bits[30:23]) && (|bits[22:0]);
         inf = (&bits[30:23]) && !(|bits[22:0]);
         neg = bits[31];
         v   = (nan || inf) ? 0.0 : sgl_val(bits[31:0]);
      end
      w  = wd ? 32 : 16;
      fb = w - int'(im);
      sc = v * (2.0 ** real'(fb));
      einv = 1'b0; over_frac = 1'b0; sticky = 1'b0; eres = '0;
      if (nan) begin
         eres = '0; einv = 1'b1;
      end else if (sgn) begin
         hi_r = (2.0 ** real'(w - 1)) - 1.0;
         lo_r = -(2.0 ** real'(w - 1));
         if ((inf && !neg) || (!inf && sc > hi_r)) begin
            eres = 64'(trunc_r(hi_r)); einv = 1'b1;
            over_frac = !inf && (sc < hi_r + 1.0);
         end else if ((inf && neg) || sc < lo_r) begin
            eres = 64'(trunc_r(lo_r)); einv = 1'b1;
            over_frac = !inf && (sc > lo_r - 1.0);
         end else begin
            t = trunc_r(sc); eres = 64'(t); sticky = (real'(t) != sc);
         end
      end else begin
         um_r = (2.0 ** real'(w)) - 1.0;
         if (neg && (inf || sc != 0.0)) begin
            eres = '0; einv = 1'b1;
         end else if (inf || sc > um_r) begin
            eres = 64'(trunc_r(um_r)); einv = 1'b1;
            over_frac = !inf && (sc < um_r + 1.0);
         end else begin
            t = trunc_r(sc); eres = 64'(t); sticky = (real'(t) != sc);
         end
      end
      if (nan)              tag = "R7";
      else if (inf)         tag = "R8";
      else if (over_frac)   tag = "R6";
      else if (einv && !sgn) tag = "R5";
      else if (einv && wd)  tag = "R4";
      else if (einv)        tag = "R3";
      else if (dbl)         tag = "R9";
      else if (!sgn)        tag = "R11";
      else if (sticky)      tag = "R2";
      else                  tag = "R1";

      in_valid  = 1'b1;
      is_double = dbl;
      is_signed = sgn;
      is_word   = wd;
      imm_lo    = im[0];
      imm_hi    = im[4:1];
      op_lo     = bits[31:0];
      op_hi     = dbl ? bits[63:32] : rnd();
      @(negedge clk);
      got = {res_hi, res_lo};
      n_chk++;
      if (!out_valid || got !== eres || invalid !== einv) begin
         n_fail++;
         $display("FAIL %s dbl=%0d sgn=%0d word=%0d imm=%0d op=%h: got vld=%b res=%h inv=%b, expected vld=1 res=%h inv=%b",
                  tag, dbl, sgn, wd, im, bits, out_valid, got, invalid, eres, einv);
      end
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run did not finish, got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin : main
      logic [63:0] prev;
      bit          s;
      int          e;
      logic [22:0] f;
      repeat (3) @(negedge clk);
      // R10: reset state
      n_chk++;
      if (out_valid !== 1'b0 || {res_hi, res_lo} !== 64'h0 || invalid !== 1'b0) begin
         n_fail++;
         $display("FAIL R10 reset: got vld=%b res=%h inv=%b expected 0/0/0",
                  out_valid, {res_hi, res_lo}, invalid);
      end
      rst_n = 1'b1;
      @(negedge clk);

      for (int d = 0; d < 2; d++)
         for (int sg = 0; sg < 2; sg++)
            for (int wd = 0; wd < 2; wd++)
               for (int im = 0; im < 32; im++) begin
                  for (int i = 0; i < 22; i++) begin
                     entry(i, s, e, f);
                     run_op(d[0], sg[0], wd[0], 5'(im), mk(d[0], s, e, f, 29'(rnd())));
                  end
                  for (int k = 0; k < 10; k++) begin
                     logic [31:0] r;
                     r = rnd();
                     run_op(d[0], sg[0], wd[0], 5'(im),
                            mk(d[0], r[31], int'(r[30:25] % 6'd56) - 20, 23'(rnd()), 29'(rnd())));
                  end
               end

      // R10: outputs hold and valid drops when no new operand is offered
      in_valid = 1'b0;
      prev = {res_hi, res_lo};
      @(negedge clk);
      prev = {res_hi, res_lo};
      op_lo = 32'h3F80_0000;
      op_hi = rnd();
      is_signed = ~is_signed;
      @(negedge clk);
      n_chk++;
      if (out_valid !== 1'b0 || {res_hi, res_lo} !== prev) begin
         n_fail++;
         $display("FAIL R10 hold: got vld=%b res=%h expected vld=0 res=%h",
                  out_valid, {res_hi, res_lo}, prev);
      end

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule